// File: doc/BRIEF.md
# Add/Subtract Arithmetic Unit with Status Flags

This block performs five arithmetic operations on a source and a destination operand: plain add, add with carry, subtract, subtract with carry, and compare. All five share one binary adder. Subtraction is done by feeding the adder the bitwise-inverted source together with a chosen carry-in, so that the sum equals dst + (src' + carry-in). The block works on either a full 16-bit word or on the low byte only. A carry value taken from the surrounding status word serves as the carry-in for the two with-carry forms.

Requests enter through a valid/ready port and results leave through a valid/ready port, with one register stage in between. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output stage holds its contents. Each result comes with a destination write-enable. Compare drops that enable and still updates the flags.

The four status flags (carry, zero, negative, overflow) sit in a register. That register is loaded on the same edge that accepts a request with a defined opcode, and it is cleared by reset.

Top module: `alu_addsub`

## Requirements
- R1: Opcode 0 (add) produces dst + src with a carry-in of 0.
- R2: Opcode 1 (add with carry) produces dst + src + `in_carry`.
- R3: Opcode 2 (subtract) and opcode 4 (compare) produce dst + ~src + 1, which is dst − src.
- R4: Opcode 3 (subtract with carry) produces dst + ~src + `in_carry`.
- R5: `out_we` is 0 for compare and 1 for opcodes 0 to 3. Compare still updates all four flags.
- R6: `flag_c` is the carry out of the top bit of the active width. For the subtract forms, 1 means no borrow.
- R7: `flag_v` is 1 when dst and the adder's second operand (src or ~src) have the same sign bit and the result's sign bit differs from it. This also covers the case where the carry-in alone moves the sum across the sign boundary.
- R8: `flag_z` is 1 exactly when the active-width result is zero. `flag_n` is the top bit of the active-width result.
- R9: With `in_byte`=1, only bits 7:0 take part. Carry leaves from bit 7, negative and overflow use bit 7, and `out_result[15:8]` is 0.
- R10: Opcodes 5 to 7 return dst (masked to the active width) with `out_we`=0 and leave all four flags unchanged.
- R11: `in_ready` = !`out_valid` | `out_ready`. A request accepted on one edge appears at the output after that edge. The output holds steady while `out_valid`=1 and `out_ready`=0.
- R12: While reset is active, `out_valid` goes to 0 and all four flags go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_op | input | 3 | Opcode: 0 add, 1 add-carry, 2 sub, 3 sub-carry, 4 compare |
| in_byte | input | 1 | 1 = low-byte operation, 0 = full word |
| in_src | input | 16 | Source operand |
| in_dst | input | 16 | Destination operand |
| in_carry | input | 1 | Carry taken from the status word |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_result | output | 16 | Sum in the active width |
| out_we | output | 1 | Destination write-enable |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench targets several corner cases, each tied to a typical design fault:
- **Carry-in at the sign boundary.** It drives 0x7FFF with a carry-in of 1. A design that takes overflow from the effective operand (src' + carry) would see that operand wrap to 0x8000 and miss the overflow.
- **Equal-operand subtraction and compare.** These must give zero with carry set. A reversed borrow convention would show carry clear.
- **Byte-mode wraparound.** This exposes carry taken from bit 15, or nonzero upper bits.
- **Stalled output.** A stall must keep the result steady. A broken ready term would drop or duplicate a result.

A behavioural model built on signed and unsigned integer arithmetic is compared every cycle under random back-pressure. Undefined opcodes are sent between defined ones, so any flag write or write-enable they cause shows up at once.

// File: rtl/alu_addsub_pkg.sv
package alu_addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBC = 3'd3,
    OP_CMP  = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/alu_operand_sel.sv
// Picks the adder's second operand (raw or inverted source) and its carry-in,
// and decodes whether the result is written and whether flags update.
module alu_operand_sel
  import alu_addsub_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] src,
  input  logic              carry,
  output logic [DATA_W-1:0] opnd,
  output logic              cin,
  output logic              we,
  output logic              upd
);

  always_comb begin
    opnd = '0;
    cin  = 1'b0;
    we   = 1'b0;
    upd  = 1'b0;
    case (op)
      OP_ADD: begin
        opnd = src;
        we   = 1'b1;
        upd  = 1'b1;
      end
      OP_ADDC: begin
        opnd = src;
        cin  = carry;
        we   = 1'b1;
        upd  = 1'b1;
      end
      OP_SUB: begin
        opnd = ~src;
        cin  = 1'b1;
        we   = 1'b1;
        upd  = 1'b1;
      end
      OP_SUBC: begin
        opnd = ~src;
        cin  = carry;
        we   = 1'b1;
        upd  = 1'b1;
      end
      OP_CMP: begin
        opnd = ~src;
        cin  = 1'b1;
        upd  = 1'b1;
      end
      default: begin
        opnd = '0;
      end
    endcase
  end

endmodule

// File: rtl/alu_adder.sv
// One shared adder with a narrow lane for byte mode; reports the sum, the
// carry out of the active width and the two operand sign bits.
module alu_adder #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              byte_mode,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              a_msb,
  output logic              b_msb
);

  localparam int UPPER_W = DATA_W - BYTE_W;

  logic [DATA_W:0] wide_sum;
  assign wide_sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};

  generate
    if (UPPER_W > 0) begin : g_lanes
      logic [BYTE_W:0] narrow_sum;
      assign narrow_sum = {1'b0, a[BYTE_W-1:0]} + {1'b0, b[BYTE_W-1:0]}
                        + {{BYTE_W{1'b0}}, cin};
      always_comb begin
        if (byte_mode) begin
          sum   = {{UPPER_W{1'b0}}, narrow_sum[BYTE_W-1:0]};
          cout  = narrow_sum[BYTE_W];
          a_msb = a[BYTE_W-1];
          b_msb = b[BYTE_W-1];
        end else begin
          sum   = wide_sum[DATA_W-1:0];
          cout  = wide_sum[DATA_W];
          a_msb = a[DATA_W-1];
          b_msb = b[DATA_W-1];
        end
      end
    end else begin : g_single
      logic unused_mode;
      assign unused_mode = byte_mode;
      assign sum   = wide_sum[DATA_W-1:0];
      assign cout  = wide_sum[DATA_W];
      assign a_msb = a[DATA_W-1];
      assign b_msb = b[DATA_W-1];
    end
  endgenerate

endmodule

// File: rtl/alu_flag_gen.sv
// Derives carry, zero, negative and overflow from the adder outputs.
module alu_flag_gen
  import alu_addsub_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] sum,
  input  logic              cout,
  input  logic              a_msb,
  input  logic              b_msb,
  input  logic              byte_mode,
  output alu_flags_t        flags
);

  logic res_msb;
  logic res_zero;

  always_comb begin
    if (byte_mode) begin
      res_msb  = sum[BYTE_W-1];
      res_zero = (sum[BYTE_W-1:0] == '0);
    end else begin
      res_msb  = sum[DATA_W-1];
      res_zero = (sum == '0);
    end
    flags.c = cout;
    flags.z = res_zero;
    flags.n = res_msb;
    flags.v = (a_msb == b_msb) && (res_msb != a_msb);
  end

endmodule

// File: rtl/alu_addsub.sv
// Top: valid/ready request port, one output register stage, flag register.
module alu_addsub
  import alu_addsub_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic              in_byte,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_dst,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_we,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_v
);

  logic [DATA_W-1:0] opnd;
  logic              cin;
  logic              we_c;
  logic              upd_c;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic              a_msb;
  logic              b_msb;
  alu_flags_t        flags_c;
  alu_flags_t        flags_q;
  logic              accept;

  alu_operand_sel #(.DATA_W(DATA_W)) u_sel (
    .op    (in_op),
    .src   (in_src),
    .carry (in_carry),
    .opnd  (opnd),
    .cin   (cin),
    .we    (we_c),
    .upd   (upd_c)
  );

  alu_adder #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_add (
    .a         (in_dst),
    .b         (opnd),
    .cin       (cin),
    .byte_mode (in_byte),
    .sum       (sum),
    .cout      (cout),
    .a_msb     (a_msb),
    .b_msb     (b_msb)
  );

  alu_flag_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_flags (
    .sum       (sum),
    .cout      (cout),
    .a_msb     (a_msb),
    .b_msb     (b_msb),
    .byte_mode (in_byte),
    .flags     (flags_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_we     <= 1'b0;
      flags_q    <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= sum;
        out_we     <= we_c;
        if (upd_c) begin
          flags_q <= flags_c;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign flag_c = flags_q.c;
  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_v = flags_q.v;

endmodule

// File: rtl/alu_addsub_chk.sv
module alu_addsub_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic              in_byte,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_we,
  input logic              flag_c,
  input logic              flag_z,
  input logic              flag_n,
  input logic              flag_v
);

  logic acc;
  assign acc = in_valid && in_ready;

  // R11: a stalled result stays put
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_we));

  // R5: compare never writes the destination
  p_cmp_nowe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 3'd4 |=> out_valid && !out_we);

  // R9: byte results keep the upper byte clear
  p_byte_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_byte |=> out_result[DATA_W-1:BYTE_W] == '0);

  // R8: zero flag agrees with the registered result
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op <= 3'd4 |=> flag_z == (out_result == '0));

  // R10: undefined opcodes leave flags alone and do not write
  p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op > 3'd4 |=> $stable({flag_c, flag_z, flag_n, flag_v}) && !out_we);

  // R12: reset empties the stage and clears the flags
  p_reset_r12: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !flag_c && !flag_z && !flag_n && !flag_v);

endmodule

bind alu_addsub alu_addsub_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/alu_addsub_test.sv
module alu_addsub_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic        in_byte = 1'b0;
  logic [15:0] in_src = 16'h0;
  logic [15:0] in_dst = 16'h0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic        out_we;
  logic        flag_c, flag_z, flag_n, flag_v;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_valid = 1'b0;
  longint      m_res = 0;
  bit          m_we = 1'b0;
  bit          m_c = 1'b0, m_z = 1'b0, m_n = 1'b0, m_v = 1'b0;
  string       m_tag = "R1";

  always #5 clk = ~clk;

  alu_addsub uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_byte(in_byte), .in_src(in_src), .in_dst(in_dst),
    .in_carry(in_carry), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_we(out_we), .flag_c(flag_c),
    .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
  );

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // compare all outputs against the model (called just after a falling edge)
  task automatic compare_outputs();
    check("R11 out_valid", longint'(out_valid), longint'(m_valid));
    if (m_valid) begin
      check({m_tag, " result"}, longint'(out_result), m_res);
      check("R5 out_we", longint'(out_we), longint'(m_we));
    end
    check("R6 flag_c", longint'(flag_c), longint'(m_c));
    check("R7 flag_v", longint'(flag_v), longint'(m_v));
    check("R8 flag_z", longint'(flag_z), longint'(m_z));
    check("R8 flag_n", longint'(flag_n), longint'(m_n));
  endtask

  // behavioural arithmetic using integer add/subtract on signed and unsigned views
  task automatic model_accept(bit [2:0] op, bit byt, bit [15:0] src, bit [15:0] dst, bit cy);
    longint w   = byt ? 8 : 16;
    longint md  = longint'(1) << w;
    longint a   = longint'(dst) % md;
    longint s   = longint'(src) % md;
    longint sa  = (a >= md / 2) ? a - md : a;
    longint ss  = (s >= md / 2) ? s - md : s;
    longint ci  = 0;
    longint u   = 0;
    longint sg  = 0;
    bit     sub = 1'b0;
    m_valid = 1'b1;
    if (op > 3'd4) begin
      m_res = a;
      m_we  = 1'b0;
      m_tag = "R10";
      return;
    end
    case (op)
      3'd0: begin ci = 0; m_tag = "R1"; end
      3'd1: begin ci = longint'(cy); m_tag = "R2"; end
      3'd2: begin ci = 1; sub = 1'b1; m_tag = "R3"; end
      3'd3: begin ci = longint'(cy); sub = 1'b1; m_tag = "R4"; end
      default: begin ci = 1; sub = 1'b1; m_tag = "R3"; end
    endcase
    if (byt) m_tag = "R9";
    if (!sub) begin
      u   = a + s + ci;
      sg  = sa + ss + ci;
      m_c = (u >= md);
      m_res = u % md;
    end else begin
      u   = a - s - 1 + ci;
      sg  = sa - ss - 1 + ci;
      m_c = (u >= 0);
      m_res = (u + md) % md;
    end
    m_v  = (sg >= md / 2) || (sg < -(md / 2));
    m_z  = (m_res == 0);
    m_n  = (m_res >= md / 2);
    m_we = (op != 3'd4);
  endtask

  task automatic step(bit v, bit [2:0] op, bit byt, bit [15:0] src, bit [15:0] dst,
                      bit cy, bit rdy);
    bit exp_ready;
    @(negedge clk);
    compare_outputs();
    in_valid  = v;
    in_op     = op;
    in_byte   = byt;
    in_src    = src;
    in_dst    = dst;
    in_carry  = cy;
    out_ready = rdy;
    #1;
    exp_ready = !m_valid || rdy;
    check("R11 in_ready", longint'(in_ready), longint'(exp_ready));
    if (v && exp_ready) model_accept(op, byt, src, dst, cy);
    else if (rdy) m_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: state while reset is held
    check("R12 out_valid", longint'(out_valid), 0);
    check("R12 flags", longint'({flag_c, flag_z, flag_n, flag_v}), 0);
    rst_n = 1'b1;

    step(1, 3'd0, 0, 16'h0001, 16'h0002, 1, 1);  // R1 carry ignored
    step(1, 3'd1, 0, 16'h7FFF, 16'h0000, 1, 1);  // R2/R7 carry-in crosses sign
    step(1, 3'd2, 0, 16'h1234, 16'h1234, 0, 1);  // R3 equal -> zero, carry set
    step(1, 3'd2, 0, 16'h0001, 16'h0000, 0, 1);  // R3/R6 borrow
    step(1, 3'd3, 0, 16'h0001, 16'h8000, 0, 1);  // R4/R7
    step(1, 3'd4, 0, 16'h0005, 16'h0005, 0, 1);  // R5 compare
    step(1, 3'd0, 1, 16'hAB01, 16'hCDFF, 0, 1);  // R9 byte wrap
    step(1, 3'd1, 1, 16'h007F, 16'h0000, 1, 1);  // R9/R7 byte overflow via carry
    step(1, 3'd6, 0, 16'hFFFF, 16'h4321, 1, 1);  // R10 undefined
    step(1, 3'd5, 1, 16'h0000, 16'h1280, 0, 1);  // R10 undefined, byte
    step(1, 3'd0, 0, 16'hFFFF, 16'h0001, 0, 0);  // R11 stall begins
    step(1, 3'd2, 0, 16'h0003, 16'h0009, 0, 0);  // R11 blocked request
    step(1, 3'd2, 0, 16'h0003, 16'h0009, 0, 1);  // R11 drain and accept
    step(0, 3'd0, 0, 16'h0000, 16'h0000, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      step(($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), 1'($urandom),
           16'($urandom), 16'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0));
    end
    step(0, 3'd0, 0, 16'h0, 16'h0, 0, 1);
    @(negedge clk);
    compare_outputs();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule